// File: doc/BRIEF.md
# Power Button Shutdown Sequencer

This block turns a single push button into an orderly power-down handshake with a host processor. While the system is powered, a press of the button does not cut power at once. It starts a countdown in two stages. When the first stage ends, the block raises a shutdown flag for the host to see. The second stage then gives the host time to react. Within that window the host may cancel the shutdown, which returns the system to normal operation, or ask for power to be removed at once. If the host does nothing, power is removed when the second stage runs out.

The button line is asynchronous and idle high. It is synchronized and watched for falling edges only, so holding or releasing the button never changes a sequence already in progress. While the system is off, a falling edge or a power-up request turns power back on. Each stage length is a programmable count of prescaled ticks, and the count is taken when the stage begins. Host commands arrive as single-cycle strobes that are synchronous to the block clock.

Top module: `pwr_btn_seq`

## Requirements
- R1: After reset the block is off: `state_o` = 0, `pwr_en_o` = 0, `shdn_flag_o` = 0.
- R2: While off, a falling edge on `btn_n_i` turns power on (`state_o` = 1) on the third rising clock edge after the low level is first sampled. A one-cycle `pwr_up_req_i` turns power on at the next edge. A steady high level or a rising edge has no effect.
- R3: While on, a falling edge starts the first stage (`state_o` = 2). `shdn_flag_o` rises exactly PRESC_DIV*(D1+1) cycles after the stage starts. D1 is the value of `dly1_i` taken when the stage starts.
- R4: The second stage (`state_o` = 3) lasts exactly PRESC_DIV*(D2+1) cycles, with D2 taken from `dly2_i` when the stage starts. With no host command, the block then goes off, with `pwr_en_o` = 0 and `shdn_flag_o` = 0.
- R5: `host_abort_i` during the second stage returns the block to on (`state_o` = 1) at the next edge and clears the flag. An abort in any other state is ignored.
- R6: `host_now_i` during the second stage turns power off at the next edge. In any other state it is ignored.
- R7: If both commands arrive together, shutdown-now wins. A command given in the cycle in which the second stage expires takes priority over the expiry.
- R8: Button edges and button release during either stage have no effect on that stage.
- R9: Changing `dly1_i` or `dly2_i` while a stage is running does not change that stage's length.
- R10: `state_o` encoding: 0 off, 1 on, 2 first stage, 3 second stage. `pwr_en_o` = 1 exactly in states 1 to 3, and `shdn_flag_o` = 1 exactly in state 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_n_i | input | 1 | Asynchronous button line, idle high, active on falling edge |
| host_abort_i | input | 1 | Single-cycle host strobe that cancels the shutdown |
| host_now_i | input | 1 | Single-cycle host strobe that forces immediate power-off |
| pwr_up_req_i | input | 1 | Single-cycle power-up request while off |
| dly1_i | input | DLY_W | First-stage length in ticks minus one |
| dly2_i | input | DLY_W | Second-stage length in ticks minus one |
| shdn_flag_o | output | 1 | Shutdown pending flag for the host |
| pwr_en_o | output | 1 | Power enable |
| state_o | output | 2 | Sequencing state code |

## Verification
A wrong state code or a timer that loads the wrong value shows directly on `state_o`, `shdn_flag_o` and `pwr_en_o`. The stage lengths are the most sensitive part: a tick miscount moves the flag edge or the power-off edge by whole prescaler periods, so the bench measures each stage to the cycle over every pair of delay values. Command and button mishandling shows within one to three cycles of the stimulus, as a state that moves when it should hold or holds when it should move.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_ON  = 2'd1,
        ST_P1  = 2'd2,
        ST_P2  = 2'd3
    } pbs_state_e;

    typedef struct packed {
        logic fall;
        logic abort;
        logic now;
        logic up_req;
        logic expire;
    } pbs_evt_t;

    function automatic logic pbs_powered(pbs_state_e s);
        return s != ST_OFF;
    endfunction

    function automatic int pbs_cnt_w(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pbs_sync_edge.sv
module pbs_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_n,
    output logic fall
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= raw_n;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= chain[SYNC_STAGES-1];
    end

    assign fall = prev & ~chain[SYNC_STAGES-1];
endmodule

// File: rtl/pbs_prescaler.sv
module pbs_prescaler #(
    parameter int PRESC_DIV = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int CW = pbs_pkg::pbs_cnt_w(PRESC_DIV);

    generate
        if (PRESC_DIV <= 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_count
            logic [CW-1:0] cnt;
            assign tick = (cnt == CW'(PRESC_DIV - 1));
            always_ff @(posedge clk) begin
                if (rst || restart) cnt <= '0;
                else if (tick)      cnt <= '0;
                else                cnt <= cnt + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/pbs_delay_timer.sv
module pbs_delay_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             cancel,
    input  logic             tick,
    output logic             expire
);
    logic [DLY_W-1:0] remain;
    logic             armed;

    assign expire = armed & tick & (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
            armed  <= 1'b0;
        end else if (load) begin
            remain <= load_val;
            armed  <= 1'b1;
        end else if (cancel) begin
            armed  <= 1'b0;
        end else if (armed && tick) begin
            if (remain == '0) armed  <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/pwr_btn_seq.sv
module pwr_btn_seq #(
    parameter int PRESC_DIV   = 1000,
    parameter int DLY_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             btn_n_i,
    input  logic             host_abort_i,
    input  logic             host_now_i,
    input  logic             pwr_up_req_i,
    input  logic [DLY_W-1:0] dly1_i,
    input  logic [DLY_W-1:0] dly2_i,
    output logic             shdn_flag_o,
    output logic             pwr_en_o,
    output logic [1:0]       state_o
);
    import pbs_pkg::*;

    pbs_state_e       state_q, state_d;
    pbs_evt_t         evt;
    logic             btn_fall, tick, tmr_expire;
    logic             tmr_load, tmr_cancel;
    logic [DLY_W-1:0] tmr_val;

    pbs_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw_n (btn_n_i),
        .fall  (btn_fall)
    );

    pbs_prescaler #(.PRESC_DIV(PRESC_DIV)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .restart (tmr_load),
        .tick    (tick)
    );

    pbs_delay_timer #(.DLY_W(DLY_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cancel   (tmr_cancel),
        .tick     (tick),
        .expire   (tmr_expire)
    );

    always_comb begin
        evt.fall   = btn_fall;
        evt.abort  = host_abort_i;
        evt.now    = host_now_i;
        evt.up_req = pwr_up_req_i;
        evt.expire = tmr_expire;
    end

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = dly1_i;
        unique case (state_q)
            ST_OFF: if (evt.fall || evt.up_req) state_d = ST_ON;
            ST_ON: begin
                if (evt.fall) begin
                    state_d  = ST_P1;
                    tmr_load = 1'b1;
                    tmr_val  = dly1_i;
                end
            end
            ST_P1: begin
                if (evt.expire) begin
                    state_d  = ST_P2;
                    tmr_load = 1'b1;
                    tmr_val  = dly2_i;
                end
            end
            ST_P2: begin
                if (evt.now)         state_d = ST_OFF;
                else if (evt.abort)  state_d = ST_ON;
                else if (evt.expire) state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
        tmr_cancel = (state_d == ST_ON) || (state_d == ST_OFF);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_OFF;
        else     state_q <= state_d;
    end

    assign state_o     = state_q;
    assign pwr_en_o    = pbs_powered(state_q);
    assign shdn_flag_o = (state_q == ST_P2);
endmodule

// File: rtl/pbs_chk.sv
module pbs_chk (
    input logic       clk,
    input logic       rst,
    input logic       host_abort_i,
    input logic       host_now_i,
    input logic       shdn_flag_o,
    input logic       pwr_en_o,
    input logic [1:0] state_o
);
    // R10
    flag_in_p2_chk: assert property (@(posedge clk) disable iff (rst)
        shdn_flag_o |-> (pwr_en_o && state_o == 2'd3));

    // R6
    now_off_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd3 && host_now_i) |=> (state_o == 2'd0 && !pwr_en_o));

    // R5
    abort_on_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd3 && host_abort_i && !host_now_i) |=> (state_o == 2'd1 && !shdn_flag_o));

    // R4
    off_from_p2_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_en_o) |-> $past(state_o) == 2'd3);

    // R3
    flag_from_p1_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(shdn_flag_o) |-> $past(state_o) == 2'd2);

    // R8
    p1_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd2) |=> (state_o == 2'd2 || state_o == 2'd3));
endmodule

bind pwr_btn_seq pbs_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .host_abort_i (host_abort_i),
    .host_now_i   (host_now_i),
    .shdn_flag_o  (shdn_flag_o),
    .pwr_en_o     (pwr_en_o),
    .state_o      (state_o)
);

// File: tb/pwr_btn_seq_tb.sv
module pwr_btn_seq_tb;
    localparam int PD = 4;
    localparam int DW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          btn = 1'b1;
    logic          abrt = 1'b0;
    logic          now = 1'b0;
    logic          upr = 1'b0;
    logic [DW-1:0] d1 = '0;
    logic [DW-1:0] d2 = '0;
    logic          flag, pen;
    logic [1:0]    st;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    pwr_btn_seq #(.PRESC_DIV(PD), .DLY_W(DW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .btn_n_i(btn), .host_abort_i(abrt),
        .host_now_i(now), .pwr_up_req_i(upr), .dly1_i(d1), .dly2_i(d2),
        .shdn_flag_o(flag), .pwr_en_o(pen), .state_o(st)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_up();
        end
    end

    task automatic wait_st(input logic [1:0] s, output int n);
        n = 0;
        while (st != s && n < 1000) begin
            step(1);
            n++;
        end
    endtask

    task automatic press;
        btn = 1'b0;
        step(2);
        btn = 1'b1;
        step(3);
    endtask

    task automatic pulse_up;
        upr = 1'b1;
        step(1);
        upr = 1'b0;
    endtask

    initial begin
        int n;
        step(3);
        rst = 1'b0;
        // R1 reset state
        chk(st == 2'd0, "R1 state", st, 0);
        chk(pen == 1'b0, "R1 pwr_en", pen, 0);
        chk(flag == 1'b0, "R1 flag", flag, 0);

        // R2 steady high does nothing; falling edge turns on after 3 edges
        step(10);
        chk(st == 2'd0, "R2 idle high", st, 0);
        btn = 1'b0;
        step(2);
        chk(st == 2'd0, "R2 too early", st, 0);
        step(1);
        chk(st == 2'd1, "R2 edge on", st, 1);
        chk(pen == 1'b1, "R10 pwr_en on", pen, 1);
        btn = 1'b1;
        step(4);

        // R3 R4 R8 R9 sweep over every delay pair
        for (int a = 0; a < (1 << DW); a++) begin
            for (int b = 0; b < (1 << DW); b++) begin
                d1 = DW'(a);
                d2 = DW'(b);
                btn = 1'b0;
                wait_st(2'd2, n);
                chk(st == 2'd2, "R3 enter stage1", st, 2);
                n = 0;
                while (st == 2'd2 && n < 1000) begin
                    step(1);
                    n++;
                    if (n == 1) begin d1 = ~DW'(a); abrt = 1'b1; btn = 1'b1; end
                    if (n == 2) begin abrt = 1'b0; btn = 1'b0; end
                    if (n == 3) btn = 1'b1;
                end
                chk(n == PD * (a + 1), "R3 R9 stage1 length", n, PD * (a + 1));
                chk(flag == 1'b1 && st == 2'd3, "R3 flag", flag, 1);
                n = 0;
                while (st == 2'd3 && n < 1000) begin
                    step(1);
                    n++;
                    if (n == 1) begin d2 = ~DW'(b); btn = 1'b0; end
                    if (n == 2) btn = 1'b1;
                end
                chk(n == PD * (b + 1), "R4 R8 R9 stage2 length", n, PD * (b + 1));
                chk(st == 2'd0 && !pen && !flag, "R4 off", st, 0);
                step(3);
                pulse_up();
                chk(st == 2'd1, "R2 power-up request", st, 1);
                step(2);
            end
        end

        // R5 abort in stage 2
        d1 = 3'd1;
        d2 = 3'd7;
        press();
        wait_st(2'd3, n);
        step(2);
        abrt = 1'b1;
        step(1);
        abrt = 1'b0;
        chk(st == 2'd1, "R5 abort state", st, 1);
        chk(flag == 1'b0, "R5 abort flag", flag, 0);

        // R5 R6 commands while on are ignored
        abrt = 1'b1; now = 1'b1;
        step(1);
        abrt = 1'b0; now = 1'b0;
        step(2);
        chk(st == 2'd1, "R5 R6 ignored while on", st, 1);

        // R6 shutdown-now in stage 1 ignored
        d1 = 3'd7;
        press();
        chk(st == 2'd2, "R6 in stage1", st, 2);
        now = 1'b1;
        step(1);
        now = 1'b0;
        step(1);
        chk(st == 2'd2, "R6 ignored in stage1", st, 2);

        // R6 shutdown-now in stage 2, button held low into off, then released
        wait_st(2'd3, n);
        btn = 1'b0;
        step(4);
        now = 1'b1;
        step(1);
        now = 1'b0;
        chk(st == 2'd0 && !pen, "R6 now off", st, 0);
        btn = 1'b1;
        step(6);
        chk(st == 2'd0, "R2 rising edge ignored", st, 0);

        // R7 both commands: now wins
        pulse_up();
        d1 = 3'd0;
        step(2);
        press();
        wait_st(2'd3, n);
        abrt = 1'b1; now = 1'b1;
        step(1);
        abrt = 1'b0; now = 1'b0;
        chk(st == 2'd0, "R7 now beats abort", st, 0);

        // R7 abort in expiry cycle wins over expiry
        pulse_up();
        d2 = 3'd0;
        step(2);
        btn = 1'b0;
        wait_st(2'd3, n);
        btn = 1'b1;
        step(3);
        abrt = 1'b1;
        step(1);
        abrt = 1'b0;
        chk(st == 2'd1, "R7 abort at expiry", st, 1);

        finish_up();
    end
endmodule